// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's load/store port and a slower line-wide memory port. It holds a parameterised number of lines. Each line has a valid flag, a dirty flag, a stored tag and the line data. A byte address is cut into three fields: the offset within the line, the line index, and the tag above the index. A request that finds its line valid and its tag matching is a hit. A hit answers on the clock after acceptance, and a write hit changes only the cached copy and marks the line dirty.

A request that misses holds off the processor until the miss has been handled:

- If the line being replaced is dirty, its contents are written to memory.
- The wanted line is then read from memory and installed clean.
- The original read or write is then completed on the fresh line.

A write miss therefore allocates the line before it merges its word. Memory transfers use a request held until a one-cycle acknowledge, so the memory may take any number of cycles.

Top module: `dm_wb_cache`

## Requirements
- R1: The byte address is split as offset = bits [OFF_W-1:0], index = the next IDX_W bits, and tag = all bits above those, where OFF_W = log2(LINE_BYTES) and IDX_W = log2(LINES). With the defaults (32-bit address, 64 lines of 16 bytes) this gives offset 3:0, index 9:4 and tag 31:10. Byte address 1200 therefore uses line 11, and its line is written back at line address 1200. Word w of a line occupies line bits [32w+31:32w], and w is given by address bits above bit 1 within the offset.
- R2: A request hits only when its line is valid and the stored tag equals the address tag. After reset every line is invalid, so the first access to any line misses.
- R3: A request is accepted on a clock edge where cpu_req_valid and cpu_req_ready are both 1. On a hit, cpu_resp_valid and cpu_resp_hit are 1 on the next cycle. cpu_resp_rdata carries the addressed word for a read and the written word for a write.
- R4: A write hit updates only the cached word and marks the line dirty; it makes no memory request.
- R5: On a miss, cpu_req_ready is 0 from the cycle after acceptance until the response. The response has cpu_resp_hit = 0 and comes two cycles after the refill acknowledge.
- R6: When the replaced line is valid and dirty, a memory write of that line's data, at that line's address, completes before the refill read is issued.
- R7: When the replaced line is clean or invalid, the miss makes exactly one memory read and no write.
- R8: A write miss reads the whole line first, then overwrites only the addressed word; the other words keep their memory values and the line becomes dirty.
- R9: A line installed by a refill is valid and clean, so evicting a line that has only been read causes no write-back.
- R10: mem_req_valid, mem_req_write and mem_req_addr stay unchanged from the raising of a request until the cycle of its mem_ack.
- R11: With 8 lines of one 4-byte word each, the word-address sequence 22, 26, 22, 26, 16, 3, 16, 18 (read) gives miss, miss, hit, hit, miss, miss, hit, miss.
- R12: Every read returns the last value written to that address through the cache, or the memory's value if it was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address of the request |
| cpu_req_wdata | input | 32 | Word to write |
| cpu_req_ready | output | 1 | Cache can take a request this cycle |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_hit | output | 1 | Response came from a hit |
| cpu_resp_rdata | output | 32 | Read word, or written word for writes |
| mem_req_valid | output | 1 | Memory transfer requested |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | ADDR_W | Line-aligned memory address |
| mem_req_wdata | output | LINE_BYTES*8 | Line data for a write-back |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |
| mem_rdata | input | LINE_BYTES*8 | Line data returned by a read |

## Verification
Two events can meet in adjacent cycles and must stay ordered: the acknowledge that ends a dirty write-back, and the raising of the refill read for a different line address on the same index. Back-to-back hits can also meet, with one response pulse and the next acceptance in the same cycle. The bench provokes the first case with a memory model whose latency varies from zero to three wait cycles. It records the cycle stamp of every write and read completion and flags any change of a pending request. Each dirty eviction is then judged on three points: the write stamp precedes the read stamp, the written address is the victim's, and the written data equals the bench's own record of that line.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_REPLY = 2'd3
  } dmc_state_e;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = WORD_BYTES * 8;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 4,
  parameter int WSEL_W = 2,
  parameter int WORDS  = 4
) (
  input  logic [ADDR_W-1:0]              addr,
  output logic [ADDR_W-IDX_W-OFF_W-1:0]  tag,
  output logic [IDX_W-1:0]               idx,
  output logic [WSEL_W-1:0]              wsel
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  function automatic logic [IDX_W-1:0] index_of(logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  assign idx = index_of(addr);
  assign tag = tag_of(addr);

  generate
    if (WORDS > 1) begin : g_multi_word
      assign wsel = addr[2 +: WSEL_W];
    end else begin : g_single_word
      assign wsel = '0;
    end
  endgenerate

  logic unused_offset_bits;
  assign unused_offset_bits = ^addr[OFF_W-1:0];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int LINES  = 64,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = data_q[rd_idx];

  assert_reset_clears_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0));

  assert_dirty_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((dirty_q & ~valid_q) == '0));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 22,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 4,
  parameter int WSEL_W = 2,
  parameter int WORDS  = 4,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [WORD_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic              cpu_resp_hit,
  output logic [WORD_W-1:0] cpu_resp_rdata,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic [TAG_W-1:0]  lk_tag_req,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [WSEL_W-1:0] lk_wsel,
  input  logic              lk_hit,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [LINE_W-1:0] lk_line,
  output logic              st_wr_en,
  output logic [IDX_W-1:0]  st_wr_idx,
  output logic              st_wr_dirty,
  output logic [TAG_W-1:0]  st_wr_tag,
  output logic [LINE_W-1:0] st_wr_line,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);
  function automatic logic [WORD_W-1:0] pick_word(logic [LINE_W-1:0] line,
                                                  logic [WSEL_W-1:0] sel);
    logic [WORD_W-1:0] r;
    r = line[WORD_W-1:0];
    for (int w = 0; w < WORDS; w++)
      if (sel == WSEL_W'(w)) r = line[w*WORD_W +: WORD_W];
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] put_word(logic [LINE_W-1:0] line,
                                                 logic [WSEL_W-1:0] sel,
                                                 logic [WORD_W-1:0] val);
    logic [LINE_W-1:0] r;
    r = line;
    for (int w = 0; w < WORDS; w++)
      if (sel == WSEL_W'(w)) r[w*WORD_W +: WORD_W] = val;
    return r;
  endfunction

  dmc_state_e        st_q;
  logic              req_wr_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [WORD_W-1:0] req_wdata_q;

  logic idle, ev_accept, ev_hit, ev_miss, ev_wb_done, ev_fill_done, ev_reply;
  logic              cur_wr;
  logic [WORD_W-1:0] cur_wdata;
  logic [LINE_W-1:0] merged_line;

  assign idle         = (st_q == ST_IDLE);
  assign ev_accept    = idle && cpu_req_valid;
  assign ev_hit       = ev_accept && lk_hit;
  assign ev_miss      = ev_accept && !lk_hit;
  assign ev_wb_done   = (st_q == ST_WBACK) && mem_ack;
  assign ev_fill_done = (st_q == ST_FILL) && mem_ack;
  assign ev_reply     = (st_q == ST_REPLY);

  assign cpu_req_ready = idle;
  assign lk_addr       = idle ? cpu_req_addr : req_addr_q;
  assign cur_wr        = idle ? cpu_req_write : req_wr_q;
  assign cur_wdata     = idle ? cpu_req_wdata : req_wdata_q;
  assign merged_line   = put_word(lk_line, lk_wsel, cur_wdata);

  // single store write port: write hit, refill, or merge after refill
  assign st_wr_en    = (ev_hit && cpu_req_write) || ev_fill_done || (ev_reply && req_wr_q);
  assign st_wr_idx   = lk_idx;
  assign st_wr_tag   = lk_tag_req;
  assign st_wr_dirty = !ev_fill_done;
  assign st_wr_line  = ev_fill_done ? mem_rdata : merged_line;

  assign mem_req_valid = (st_q == ST_WBACK) || (st_q == ST_FILL);
  assign mem_req_write = (st_q == ST_WBACK);
  assign mem_req_addr  = {(st_q == ST_WBACK) ? lk_tag : lk_tag_req, lk_idx, {OFF_W{1'b0}}};
  assign mem_req_wdata = lk_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      req_wr_q       <= 1'b0;
      req_addr_q     <= '0;
      req_wdata_q    <= '0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_hit   <= 1'b0;
      cpu_resp_rdata <= '0;
    end else begin
      cpu_resp_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (ev_hit) begin
            cpu_resp_valid <= 1'b1;
            cpu_resp_hit   <= 1'b1;
            cpu_resp_rdata <= cur_wr ? cur_wdata : pick_word(lk_line, lk_wsel);
          end else if (ev_miss) begin
            req_wr_q    <= cpu_req_write;
            req_addr_q  <= cpu_req_addr;
            req_wdata_q <= cpu_req_wdata;
            st_q        <= (lk_valid && lk_dirty) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: if (ev_wb_done) st_q <= ST_FILL;
        ST_FILL:  if (ev_fill_done) st_q <= ST_REPLY;
        ST_REPLY: begin
          cpu_resp_valid <= 1'b1;
          cpu_resp_hit   <= 1'b0;
          cpu_resp_rdata <= req_wr_q ? req_wdata_q : pick_word(lk_line, lk_wsel);
          st_q           <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_hit_answers_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (cpu_resp_valid && cpu_resp_hit));

  assert_no_mem_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> !mem_req_valid);

  assert_miss_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> !cpu_req_ready);

  assert_fill_then_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> ##1 (cpu_resp_valid && !cpu_resp_hit));

  assert_wb_only_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (lk_valid && lk_dirty));

  assert_wb_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> (mem_req_valid && !mem_req_write));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ack) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  input  logic                    cpu_req_write,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [31:0]             cpu_req_wdata,
  output logic                    cpu_req_ready,
  output logic                    cpu_resp_valid,
  output logic                    cpu_resp_hit,
  output logic [31:0]             cpu_resp_rdata,
  output logic                    mem_req_valid,
  output logic                    mem_req_write,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [LINE_BYTES*8-1:0] mem_req_wdata,
  input  logic                    mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [ADDR_W-1:0] lk_addr;
  logic [TAG_W-1:0]  lk_tag_req, lk_tag, st_wr_tag;
  logic [IDX_W-1:0]  lk_idx, st_wr_idx;
  logic [WSEL_W-1:0] lk_wsel;
  logic              lk_valid, lk_dirty, lk_hit;
  logic [LINE_W-1:0] lk_line, st_wr_line;
  logic              st_wr_en, st_wr_dirty;

  dmc_addr_split #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WSEL_W(WSEL_W), .WORDS(WORDS)
  ) u_split (
    .addr(lk_addr), .tag(lk_tag_req), .idx(lk_idx), .wsel(lk_wsel)
  );

  dmc_line_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_valid(lk_valid), .rd_dirty(lk_dirty),
    .rd_tag(lk_tag), .rd_line(lk_line),
    .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_dirty(st_wr_dirty),
    .wr_tag(st_wr_tag), .wr_line(st_wr_line)
  );

  assign lk_hit = lk_valid && (lk_tag == lk_tag_req);

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .WSEL_W(WSEL_W), .WORDS(WORDS), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_hit(cpu_resp_hit), .cpu_resp_rdata(cpu_resp_rdata),
    .lk_addr(lk_addr), .lk_tag_req(lk_tag_req), .lk_idx(lk_idx), .lk_wsel(lk_wsel),
    .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .lk_tag(lk_tag), .lk_line(lk_line),
    .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_wr_dirty(st_wr_dirty),
    .st_wr_tag(st_wr_tag), .st_wr_line(st_wr_line),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/cache_mem_sim.sv
module cache_mem_sim #(
  parameter int LINE_W = 32,
  parameter int SEED   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              ack,
  output logic [LINE_W-1:0] rdata,
  output int                wr_count,
  output int                rd_count,
  output int                wr_stamp,
  output int                rd_stamp,
  output int                proto_err,
  output logic [31:0]       last_wr_addr,
  output logic [LINE_W-1:0] last_wr_data
);
  localparam int NW = LINE_W / 32;
  logic [LINE_W-1:0] store [logic [31:0]];
  int          cyc, waitc;
  logic [7:0]  lfsr;
  logic        pend, pend_wr;
  logic [31:0] pend_addr;

  function automatic logic [31:0] seed_word(logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [LINE_W-1:0] seed_line(logic [31:0] a);
    logic [LINE_W-1:0] r;
    for (int w = 0; w < NW; w++) r[w*32 +: 32] = seed_word(a + 32'(4 * w));
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; rdata <= '0; cyc <= 0; waitc <= 0; lfsr <= 8'(SEED);
      wr_count <= 0; rd_count <= 0; wr_stamp <= 0; rd_stamp <= 0; proto_err <= 0;
      pend <= 1'b0; pend_wr <= 1'b0; pend_addr <= '0;
      last_wr_addr <= '0; last_wr_data <= '0;
    end else begin
      cyc <= cyc + 1;
      ack <= 1'b0;
      if (req_valid && !ack) begin
        if (pend && (req_addr != pend_addr || req_write != pend_wr))
          proto_err <= proto_err + 1;
        pend <= 1'b1; pend_addr <= req_addr; pend_wr <= req_write;
        if (waitc >= int'(lfsr[1:0])) begin
          ack   <= 1'b1;
          waitc <= 0;
          pend  <= 1'b0;
          lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          if (req_write) begin
            store[req_addr] = req_wdata;
            wr_count     <= wr_count + 1;
            wr_stamp     <= cyc;
            last_wr_addr <= req_addr;
            last_wr_data <= req_wdata;
          end else begin
            rdata    <= store.exists(req_addr) ? store[req_addr] : seed_line(req_addr);
            rd_count <= rd_count + 1;
            rd_stamp <= cyc;
          end
        end else begin
          waitc <= waitc + 1;
        end
      end
    end
  end
endmodule

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  localparam int CLK_NS = 20;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // small instance: 8 lines of one word
  logic s_valid = 0, s_wr = 0;
  logic [31:0] s_addr = '0, s_wdata = '0;
  logic s_ready, s_rvalid, s_rhit, s_mvalid, s_mwrite, s_mack;
  logic [31:0] s_rdata, s_maddr, s_mwdata, s_mrdata, s_lwa;
  logic [31:0] s_lwd;
  int s_wrc, s_rdc, s_wst, s_rst, s_perr;

  dm_wb_cache #(.ADDR_W(32), .LINES(8), .LINE_BYTES(4)) u_dm_wb_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(s_valid), .cpu_req_write(s_wr), .cpu_req_addr(s_addr),
    .cpu_req_wdata(s_wdata), .cpu_req_ready(s_ready), .cpu_resp_valid(s_rvalid),
    .cpu_resp_hit(s_rhit), .cpu_resp_rdata(s_rdata),
    .mem_req_valid(s_mvalid), .mem_req_write(s_mwrite), .mem_req_addr(s_maddr),
    .mem_req_wdata(s_mwdata), .mem_ack(s_mack), .mem_rdata(s_mrdata)
  );

  cache_mem_sim #(.LINE_W(32), .SEED(3)) u_smem (
    .clk(clk), .rst_n(rst_n), .req_valid(s_mvalid), .req_write(s_mwrite),
    .req_addr(s_maddr), .req_wdata(s_mwdata), .ack(s_mack), .rdata(s_mrdata),
    .wr_count(s_wrc), .rd_count(s_rdc), .wr_stamp(s_wst), .rd_stamp(s_rst),
    .proto_err(s_perr), .last_wr_addr(s_lwa), .last_wr_data(s_lwd)
  );

  // default-size instance
  logic w_valid = 0, w_wr = 0;
  logic [31:0] w_addr = '0, w_wdata = '0;
  logic w_ready, w_rvalid, w_rhit, w_mvalid, w_mwrite, w_mack;
  logic [31:0] w_rdata, w_maddr, w_lwa;
  logic [127:0] w_mwdata, w_mrdata, w_lwd;
  int w_wrc, w_rdc, w_wst, w_rst, w_perr;

  dm_wb_cache u_dm_wb_cache_wide (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(w_valid), .cpu_req_write(w_wr), .cpu_req_addr(w_addr),
    .cpu_req_wdata(w_wdata), .cpu_req_ready(w_ready), .cpu_resp_valid(w_rvalid),
    .cpu_resp_hit(w_rhit), .cpu_resp_rdata(w_rdata),
    .mem_req_valid(w_mvalid), .mem_req_write(w_mwrite), .mem_req_addr(w_maddr),
    .mem_req_wdata(w_mwdata), .mem_ack(w_mack), .mem_rdata(w_mrdata)
  );

  cache_mem_sim #(.LINE_W(128), .SEED(29)) u_wmem (
    .clk(clk), .rst_n(rst_n), .req_valid(w_mvalid), .req_write(w_mwrite),
    .req_addr(w_maddr), .req_wdata(w_mwdata), .ack(w_mack), .rdata(w_mrdata),
    .wr_count(w_wrc), .rd_count(w_rdc), .wr_stamp(w_wst), .rd_stamp(w_rst),
    .proto_err(w_perr), .last_wr_addr(w_lwa), .last_wr_data(w_lwd)
  );

  function automatic logic [31:0] seed_word(logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'h5A5A_0F0F;
  endfunction

  logic [31:0] refm [logic [31:0]];
  function automatic logic [31:0] ref_rd(logic [31:0] a);
    return refm.exists(a) ? refm[a] : seed_word(a);
  endfunction

  bit sv [8];
  bit sd [8];
  int stg [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic s_go(input bit wr, input logic [31:0] a, input logic [31:0] d,
                      output bit hit, output logic [31:0] rd, output int waited,
                      output bit stall_ok);
    @(negedge clk);
    s_valid = 1'b1; s_wr = wr; s_addr = a; s_wdata = d;
    @(negedge clk);
    s_valid = 1'b0;
    waited = 0; stall_ok = 1'b1;
    while (!s_rvalid && waited < 60) begin
      if (s_ready) stall_ok = 1'b0;
      waited++;
      @(negedge clk);
    end
    hit = s_rhit; rd = s_rdata;
  endtask

  task automatic w_go(input bit wr, input logic [31:0] a, input logic [31:0] d,
                      output bit hit, output logic [31:0] rd);
    int waited;
    @(negedge clk);
    w_valid = 1'b1; w_wr = wr; w_addr = a; w_wdata = d;
    @(negedge clk);
    w_valid = 1'b0;
    waited = 0;
    while (!w_rvalid && waited < 60) begin
      waited++;
      @(negedge clk);
    end
    hit = w_rhit; rd = w_rdata;
  endtask

  // one small-cache access, judged against the bench's own line model
  task automatic s_do(input bit wr, input int word, input logic [31:0] d, output bit hit);
    logic [31:0] a, rd, vaddr;
    int idx, tg, waited, wc0, rc0;
    bit exp_hit, exp_wb, stall_ok;
    a = 32'(word * 4); idx = word % 8; tg = word / 8;
    exp_hit = sv[idx] && stg[idx] == tg;
    exp_wb  = !exp_hit && sv[idx] && sd[idx];
    vaddr   = 32'((stg[idx] * 8 + idx) * 4);
    wc0 = s_wrc; rc0 = s_rdc;
    s_go(wr, a, d, hit, rd, waited, stall_ok);
    chk(hit == exp_hit, "R2", "hit flag", 128'(hit), 128'(exp_hit));
    if (wr) chk(rd == d, "R3", "write echo", 128'(rd), 128'(d));
    else    chk(rd == ref_rd(a), "R12", "read data", 128'(rd), 128'(ref_rd(a)));
    if (exp_hit) begin
      chk(waited == 0, "R3", "hit latency", 128'(waited), 128'(0));
      chk(s_wrc == wc0 && s_rdc == rc0, "R4", "mem ops on hit",
          128'(s_wrc - wc0 + s_rdc - rc0), 128'(0));
    end else begin
      chk(stall_ok && waited >= 2, "R5", "stall while missing", 128'(waited), 128'(2));
      chk(s_rdc == rc0 + 1, "R7", "refill reads", 128'(s_rdc - rc0), 128'(1));
      chk(s_wrc == wc0 + (exp_wb ? 1 : 0), exp_wb ? "R6" : "R9", "write-backs",
          128'(s_wrc - wc0), 128'(exp_wb));
      if (exp_wb) begin
        chk(s_lwa == vaddr, "R6", "victim address", 128'(s_lwa), 128'(vaddr));
        chk(s_lwd == ref_rd(vaddr), "R6", "victim data", 128'(s_lwd), 128'(ref_rd(vaddr)));
        chk(s_wst < s_rst, "R6", "write before read", 128'(s_wst), 128'(s_rst));
      end
      sv[idx] = 1'b1; stg[idx] = tg; sd[idx] = 1'b0;
    end
    if (wr) begin
      sd[idx] = 1'b1;
      refm[a] = d;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R5 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int trace_w [8];
    bit trace_h [8];
    bit h;
    logic [31:0] rd;
    int wc0, rc0;
    trace_w = '{22, 26, 22, 26, 16, 3, 16, 18};
    trace_h = '{0, 0, 1, 1, 0, 0, 1, 0};
    for (int i = 0; i < 8; i++) begin sv[i] = 0; sd[i] = 0; stg[i] = 0; end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(s_ready == 1'b1, "R3", "ready after reset", 128'(s_ready), 128'(1));
    chk(s_rvalid == 1'b0, "R3", "no response after reset", 128'(s_rvalid), 128'(0));
    chk(s_mvalid == 1'b0, "R5", "no memory request after reset", 128'(s_mvalid), 128'(0));

    // R11: classic trace
    for (int i = 0; i < 8; i++) begin
      s_do(1'b0, trace_w[i], '0, h);
      chk(h == trace_h[i], "R11", "trace hit/miss", 128'(h), 128'(trace_h[i]));
    end

    // R4: write hit on word 22, then dirty eviction by word 30 (R6), then clean refetch (R9)
    s_do(1'b1, 22, 32'hD00D_0022, h);
    s_do(1'b0, 30, '0, h);
    s_do(1'b0, 22, '0, h);
    chk(h == 1'b0, "R9", "refetch after eviction misses", 128'(h), 128'(0));

    // R8: write miss to invalid line 1, read back, evict it
    s_do(1'b1, 41, 32'hBEEF_0041, h);
    chk(h == 1'b0, "R8", "write miss", 128'(h), 128'(0));
    s_do(1'b0, 41, '0, h);
    chk(h == 1'b1, "R8", "allocated line hits", 128'(h), 128'(1));
    s_do(1'b0, 49, '0, h);

    // sweep over all tag/index pairs with mixed reads and writes
    for (int k = 0; k < 300; k++) begin
      s_do(k % 3 == 0, (k * 13 + 5) % 64, 32'(k) * 32'h0101_0101 ^ 32'h1357_9BDF, h);
    end

    // default configuration: R1 address split and multi-word merge
    wc0 = w_wrc; rc0 = w_rdc;
    w_go(1'b1, 32'd1200, 32'hCAFE_0001, h, rd);
    chk(h == 1'b0, "R2", "first access misses", 128'(h), 128'(0));
    chk(w_wrc == wc0 && w_rdc == rc0 + 1, "R8", "write miss fetches line",
        128'(w_rdc - rc0), 128'(1));
    w_go(1'b1, 32'd1208, 32'hCAFE_0002, h, rd);
    chk(h == 1'b1, "R1", "same line hits", 128'(h), 128'(1));
    w_go(1'b0, 32'd1204, '0, h, rd);
    chk(rd == seed_word(32'd1204), "R8", "untouched word kept", 128'(rd),
        128'(seed_word(32'd1204)));
    wc0 = w_wrc;
    w_go(1'b0, 32'd2224, '0, h, rd);
    chk(w_wrc == wc0 + 1 && w_lwa == 32'd1200, "R1", "line 11 write-back address",
        128'(w_lwa), 128'(1200));
    chk(w_lwd == {seed_word(32'd1212), 32'hCAFE_0002, seed_word(32'd1204), 32'hCAFE_0001},
        "R8", "merged line data", w_lwd,
        {seed_word(32'd1212), 32'hCAFE_0002, seed_word(32'd1204), 32'hCAFE_0001});
    chk(rd == seed_word(32'd2224), "R12", "conflicting read", 128'(rd),
        128'(seed_word(32'd2224)));
    wc0 = w_wrc;
    w_go(1'b0, 32'd1200, '0, h, rd);
    chk(rd == 32'hCAFE_0001, "R12", "written word from memory", 128'(rd), 128'(32'hCAFE_0001));
    chk(w_wrc == wc0, "R9", "clean line evicted silently", 128'(w_wrc - wc0), 128'(0));
    w_go(1'b0, 32'd1216, '0, h, rd);
    w_go(1'b0, 32'd1200, '0, h, rd);
    chk(h == 1'b1, "R1", "neighbour line does not collide", 128'(h), 128'(1));

    chk(s_perr == 0 && w_perr == 0, "R10", "request held until acknowledge",
        128'(s_perr + w_perr), 128'(0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule